// File: doc/BRIEF.md
# Zero-Cross Gated Digital Volume

This block scales three independent streams of signed 24-bit audio by a per-channel attenuation chosen in half-decibel steps. Software writes an 8-bit gain code together with a channel number on a control clock that has no fixed relation to the audio clock. The write is carried into the audio clock domain by a toggle handshake. The design keeps the code word stable until the audio side has acknowledged it.

A code that reaches the audio side is not used at once. It waits as a pending setting for its channel and takes effect only after that channel's waveform passes through zero. At that instant a change in gain produces no audible step. If the signal stays on one side of zero for a long time, a sample counter forces the update so that a setting never waits forever. Each output sample is the input times a linear gain from an internal lookup, rounded and saturated back to 24 bits.

Top module: `zc_volume`

## Requirements
- R1: After reset, out_valid and out_data are zero, ctl_ready is high, and every channel uses code 255 (unity gain).
- R2: out_valid is high exactly in the cycle after a cycle with in_valid high. out_data changes only in that cycle and otherwise holds its last value.
- R3: Code 0 gives gain 0. Any other code c gives a = 255 - c and gain = M[a mod 12] >> (a div 12). M is 123740 for index 1, 116818 for 2, 110283 for 3, 104114 for 4, 98290 for 5, 92792 for 6, 87601 for 7, 82701 for 8, 78075 for 9, 73707 for 10, 69584 for 11, and 131072 (unity) for index 0.
- R4: Each channel's output is floor((s * g + 65536) / 131072), clipped to the range -8388608 to 8388607. Here s is the sample in bits [24*ch+23 : 24*ch] of in_data and g is the channel's applied gain.
- R5: A written code stays pending without effect while the channel's samples are non-zero and keep the same sign (bit 23).
- R6: A pending code is committed by a valid sample that is zero or whose sign bit differs from the channel's previous valid sample. That sample still uses the old gain, and the next sample uses the new one.
- R7: If no crossing occurs, the 1024th valid sample after the code arrives commits it. That sample uses the old gain.
- R8: A write affects only the addressed channel. A write with a channel number of 3 or more changes no channel.
- R9: A second write to a channel before its pending code commits replaces the pending code.
- R10: ctl_ready falls in the control cycle after a write is accepted (ctl_valid and ctl_ready both high) and rises again once the audio side has acknowledged the write.
- R11: A channel's applied code changes only in a cycle with in_valid high while that channel has a code pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Control clock |
| ctl_rst | input | 1 | Synchronous active-high reset, control domain |
| ctl_valid | input | 1 | Gain write request |
| ctl_chan | input | 2 | Target channel of the write |
| ctl_code | input | 8 | Gain code, 255 = 0 dB, 0 = mute |
| ctl_ready | output | 1 | High when a write can be accepted |
| aud_clk | input | 1 | Audio clock |
| aud_rst | input | 1 | Synchronous active-high reset, audio domain |
| in_valid | input | 1 | Sample beat strobe |
| in_data | input | 72 | Three packed signed 24-bit samples, channel 0 in the low bits |
| out_valid | output | 1 | Output sample beat strobe |
| out_data | output | 72 | Three packed scaled samples |

## Verification
On every cycle, the assertions check the one-cycle strobe relation, the handshake drop after an accepted write, and that the applied code only moves on a valid beat while an update is pending. They also check that a muted channel emits zero. Only the bench scenarios can show the numeric path and the timing of each commit. The bench sweeps all 256 codes at the extremes of the sample range and at a rounding value. It checks the sample on which a crossing or a zero commits, and the exact 1024th-sample timeout. It also checks that writes to one channel or to an unused channel number leave the other outputs alone.

// File: rtl/zcv_pkg.sv
package zcv_pkg;
  localparam int CODE_W     = 8;
  localparam int LIN_W      = 18;
  localparam int UNITY_SH   = LIN_W - 1;
  localparam int STEPS_OCT  = 12;
endpackage

// File: rtl/zcv_cdc_xfer.sv
module zcv_cdc_xfer #(
  parameter int W = 10
) (
  input  logic         src_clk,
  input  logic         src_rst,
  input  logic         src_valid,
  input  logic [W-1:0] src_data,
  output logic         src_ready,
  input  logic         dst_clk,
  input  logic         dst_rst,
  output logic         dst_valid,
  output logic [W-1:0] dst_data
);
  // source side
  logic         req_t;
  logic [W-1:0] hold_q;
  logic         ack_m, ack_s;
  // destination side
  logic         req_m, req_s, req_d;

  assign src_ready = (req_t == ack_s);

  always_ff @(posedge src_clk) begin
    if (src_rst) begin
      req_t  <= 1'b0;
      hold_q <= '0;
      ack_m  <= 1'b0;
      ack_s  <= 1'b0;
    end else begin
      ack_m <= req_d;
      ack_s <= ack_m;
      if (src_valid && src_ready) begin
        hold_q <= src_data;
        req_t  <= ~req_t;
      end
    end
  end

  // hold_q is stable while the toggle travels, so sampling it here is safe
  always_ff @(posedge dst_clk) begin
    if (dst_rst) begin
      req_m     <= 1'b0;
      req_s     <= 1'b0;
      req_d     <= 1'b0;
      dst_valid <= 1'b0;
      dst_data  <= '0;
    end else begin
      req_m     <= req_t;
      req_s     <= req_m;
      req_d     <= req_s;
      dst_valid <= (req_s != req_d);
      if (req_s != req_d) dst_data <= hold_q;
    end
  end
endmodule

// File: rtl/zcv_gain_lut.sv
module zcv_gain_lut
  import zcv_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [LIN_W-1:0]  lin
);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  logic [CODE_W-1:0] atten;
  logic [CODE_W-1:0] octave;
  logic [CODE_W-1:0] step;
  logic [LIN_W-1:0]  mant;

  always_comb begin
    atten  = CODE_MAX - code;
    octave = atten / CODE_W'(STEPS_OCT);
    step   = atten % CODE_W'(STEPS_OCT);
    case (step)
      CODE_W'(1):  mant = LIN_W'(123740);
      CODE_W'(2):  mant = LIN_W'(116818);
      CODE_W'(3):  mant = LIN_W'(110283);
      CODE_W'(4):  mant = LIN_W'(104114);
      CODE_W'(5):  mant = LIN_W'(98290);
      CODE_W'(6):  mant = LIN_W'(92792);
      CODE_W'(7):  mant = LIN_W'(87601);
      CODE_W'(8):  mant = LIN_W'(82701);
      CODE_W'(9):  mant = LIN_W'(78075);
      CODE_W'(10): mant = LIN_W'(73707);
      CODE_W'(11): mant = LIN_W'(69584);
      default:     mant = LIN_W'(1) << UNITY_SH;
    endcase
    if (code == '0) lin = '0;
    else            lin = mant >> octave;
  end
endmodule

// File: rtl/zcv_channel.sv
module zcv_channel
  import zcv_pkg::*;
#(
  parameter int                DW         = 24,
  parameter int                TIMEOUT    = 1024,
  parameter logic [CODE_W-1:0] RESET_CODE = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_valid,
  input  logic [CODE_W-1:0] upd_code,
  input  logic              in_valid,
  input  logic [DW-1:0]     in_sample,
  output logic [DW-1:0]     out_sample,
  output logic [CODE_W-1:0] app_code,
  output logic              pending
);
  localparam int PW  = DW + LIN_W + 1;
  localparam int CNW = $clog2(TIMEOUT) + 1;

  logic [DW-1:0]        prev_q;
  logic [CODE_W-1:0]    pend_code;
  logic [CNW-1:0]       cnt_q;
  logic [LIN_W-1:0]     app_lin;
  logic                 crossing;
  logic                 commit;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] rnd;
  logic signed [PW-1:0] shf;
  logic [DW-1:0]        sat;

  zcv_gain_lut u_lut (.code(app_code), .lin(app_lin));

  assign crossing = (in_sample == '0) || (in_sample[DW-1] != prev_q[DW-1]);
  assign commit   = in_valid && pending && !upd_valid &&
                    (crossing || (cnt_q == CNW'(TIMEOUT - 1)));

  always_comb begin
    prod = $signed({{(LIN_W+1){in_sample[DW-1]}}, in_sample}) *
           $signed({{DW{1'b0}}, 1'b0, app_lin});
    rnd  = prod + (PW'(1) <<< (UNITY_SH - 1));
    shf  = rnd >>> UNITY_SH;
    if (shf[PW-1:DW-1] == '0 || shf[PW-1:DW-1] == '1)
      sat = shf[DW-1:0];
    else
      sat = {shf[PW-1], {(DW-1){~shf[PW-1]}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q     <= '0;
      pend_code  <= '0;
      pending    <= 1'b0;
      cnt_q      <= '0;
      app_code   <= RESET_CODE;
      out_sample <= '0;
    end else begin
      if (in_valid) begin
        prev_q     <= in_sample;
        out_sample <= sat;
      end
      if (upd_valid) begin
        pend_code <= upd_code;
        pending   <= 1'b1;
        cnt_q     <= '0;
      end else if (commit) begin
        app_code <= pend_code;
        pending  <= 1'b0;
        cnt_q    <= '0;
      end else if (in_valid && pending) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/zc_volume.sv
module zc_volume
  import zcv_pkg::*;
#(
  parameter int                NCH        = 3,
  parameter int                DW         = 24,
  parameter int                TIMEOUT    = 1024,
  parameter logic [CODE_W-1:0] RESET_CODE = 8'hFF,
  localparam int               SELW       = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              ctl_clk,
  input  logic              ctl_rst,
  input  logic              ctl_valid,
  input  logic [SELW-1:0]   ctl_chan,
  input  logic [CODE_W-1:0] ctl_code,
  output logic              ctl_ready,
  input  logic              aud_clk,
  input  logic              aud_rst,
  input  logic              in_valid,
  input  logic [NCH*DW-1:0] in_data,
  output logic              out_valid,
  output logic [NCH*DW-1:0] out_data
);
  localparam int XW = SELW + CODE_W;

  logic              upd_v;
  logic [XW-1:0]     upd_d;
  logic [SELW-1:0]   upd_chan;
  logic [CODE_W-1:0] upd_code;
  logic [NCH*CODE_W-1:0] app_code_all;
  logic [NCH-1:0]        pend_all;

  zcv_cdc_xfer #(.W(XW)) u_xfer (
    .src_clk  (ctl_clk),
    .src_rst  (ctl_rst),
    .src_valid(ctl_valid),
    .src_data ({ctl_chan, ctl_code}),
    .src_ready(ctl_ready),
    .dst_clk  (aud_clk),
    .dst_rst  (aud_rst),
    .dst_valid(upd_v),
    .dst_data (upd_d)
  );

  assign upd_chan = upd_d[XW-1:CODE_W];
  assign upd_code = upd_d[CODE_W-1:0];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic hit;
    assign hit = upd_v && (upd_chan == SELW'(ch));
    zcv_channel #(
      .DW(DW), .TIMEOUT(TIMEOUT), .RESET_CODE(RESET_CODE)
    ) u_ch (
      .clk       (aud_clk),
      .rst       (aud_rst),
      .upd_valid (hit),
      .upd_code  (upd_code),
      .in_valid  (in_valid),
      .in_sample (in_data[ch*DW +: DW]),
      .out_sample(out_data[ch*DW +: DW]),
      .app_code  (app_code_all[ch*CODE_W +: CODE_W]),
      .pending   (pend_all[ch])
    );
  end

  always_ff @(posedge aud_clk) begin
    if (aud_rst) out_valid <= 1'b0;
    else         out_valid <= in_valid;
  end
endmodule

// File: rtl/zcv_checker.sv
module zcv_checker #(
  parameter int NCH = 3,
  parameter int DW  = 24,
  parameter int CW  = 8
) (
  input logic              ctl_clk,
  input logic              ctl_rst,
  input logic              ctl_valid,
  input logic              ctl_ready,
  input logic              aud_clk,
  input logic              aud_rst,
  input logic              in_valid,
  input logic              out_valid,
  input logic [NCH*DW-1:0] out_data,
  input logic [NCH*CW-1:0] app_code_all,
  input logic [NCH-1:0]    pend_all
);
  a_r2_valid_follows: assert property (@(posedge aud_clk) disable iff (aud_rst)
    in_valid |=> out_valid);
  a_r2_idle_follows: assert property (@(posedge aud_clk) disable iff (aud_rst)
    !in_valid |=> (!out_valid && $stable(out_data)));
  a_r10_ready_drops: assert property (@(posedge ctl_clk) disable iff (ctl_rst)
    (ctl_valid && ctl_ready) |=> !ctl_ready);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
    a_r11_commit_gated: assert property (@(posedge aud_clk) disable iff (aud_rst)
      !(in_valid && pend_all[ch]) |=> $stable(app_code_all[ch*CW +: CW]));
    a_r3_mute_zero: assert property (@(posedge aud_clk) disable iff (aud_rst)
      (in_valid && app_code_all[ch*CW +: CW] == '0) |=> (out_data[ch*DW +: DW] == '0));
  end
endmodule

bind zc_volume zcv_checker #(.NCH(NCH), .DW(DW), .CW(zcv_pkg::CODE_W)) u_chk (
  .ctl_clk     (ctl_clk),
  .ctl_rst     (ctl_rst),
  .ctl_valid   (ctl_valid),
  .ctl_ready   (ctl_ready),
  .aud_clk     (aud_clk),
  .aud_rst     (aud_rst),
  .in_valid    (in_valid),
  .out_valid   (out_valid),
  .out_data    (out_data),
  .app_code_all(app_code_all),
  .pend_all    (pend_all)
);

// File: tb/zc_volume_test.sv
module zc_volume_test;
  localparam int NCH = 3;
  localparam int DW  = 24;
  localparam int TO  = 1024;

  logic ctl_clk = 0, aud_clk = 0;
  logic ctl_rst = 1, aud_rst = 1;
  logic ctl_valid = 0;
  logic [1:0] ctl_chan = 0;
  logic [7:0] ctl_code = 0;
  logic ctl_ready;
  logic in_valid = 0;
  logic [NCH*DW-1:0] in_data = '0;
  logic out_valid;
  logic [NCH*DW-1:0] out_data;

  always #4 aud_clk = ~aud_clk;
  always #7 ctl_clk = ~ctl_clk;

  zc_volume uut (
    .ctl_clk(ctl_clk), .ctl_rst(ctl_rst), .ctl_valid(ctl_valid),
    .ctl_chan(ctl_chan), .ctl_code(ctl_code), .ctl_ready(ctl_ready),
    .aud_clk(aud_clk), .aud_rst(aud_rst), .in_valid(in_valid),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  int total = 0, fails = 0;
  bit done = 0;

  // model state, from the requirements
  int exp_app[NCH], exp_pcode[NCH], exp_cnt[NCH];
  bit exp_pend[NCH];
  int exp_prev[NCH];

  function automatic int gain_of(int code);
    int m[12] = '{131072, 123740, 116818, 110283, 104114, 98290,
                  92792, 87601, 82701, 78075, 73707, 69584};
    int a;
    if (code == 0) return 0;
    a = 255 - code;
    return m[a % 12] >>> (a / 12);
  endfunction

  function automatic int scale(int s, int code);
    longint p, r;
    p = longint'(s) * longint'(gain_of(code));
    r = (p + 65536) >>> 17;
    if (r > 8388607) r = 8388607;
    if (r < -8388608) r = -8388608;
    return int'(r);
  endfunction

  task automatic check(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one sample beat on all channels; checks every channel
  task automatic beat(int s0, int s1, int s2, string req);
    int s[NCH];
    int e[NCH];
    s[0] = s0; s[1] = s1; s[2] = s2;
    @(negedge aud_clk);
    in_valid = 1;
    for (int c = 0; c < NCH; c++) in_data[c*DW +: DW] = s[c][DW-1:0];
    for (int c = 0; c < NCH; c++) begin
      e[c] = scale(s[c], exp_app[c]);
      if (exp_pend[c]) begin
        if (s[c] == 0 || ((s[c] < 0) != (exp_prev[c] < 0)) || exp_cnt[c] == TO - 1) begin
          exp_app[c] = exp_pcode[c];
          exp_pend[c] = 0;
          exp_cnt[c] = 0;
        end else exp_cnt[c]++;
      end
      exp_prev[c] = s[c];
    end
    @(negedge aud_clk);
    in_valid = 0;
    check({req, " out_valid"}, out_valid, 1);
    for (int c = 0; c < NCH; c++)
      check(req, $signed(out_data[c*DW +: DW]), e[c]);
  endtask

  task automatic write(int chan, int code, bit model);
    @(negedge ctl_clk);
    while (!ctl_ready) @(negedge ctl_clk);
    ctl_valid = 1; ctl_chan = chan[1:0]; ctl_code = code[7:0];
    @(negedge ctl_clk);
    ctl_valid = 0;
    check("R10 ready low after accept", ctl_ready, 0);
    while (!ctl_ready) @(negedge ctl_clk);
    repeat (3) @(negedge aud_clk);
    if (model && chan < NCH) begin
      exp_pend[chan] = 1; exp_pcode[chan] = code; exp_cnt[chan] = 0;
    end
  endtask

  initial begin
    #3000000;
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      exp_app[c] = 255; exp_pend[c] = 0; exp_cnt[c] = 0; exp_prev[c] = 0; exp_pcode[c] = 0;
    end
    repeat (4) @(negedge ctl_clk);
    ctl_rst = 0; aud_rst = 0;
    @(negedge aud_clk);
    // R1 reset state
    check("R1 out_valid", out_valid, 0);
    check("R1 out_data", out_data, 0);
    check("R1 ctl_ready", ctl_ready, 1);
    beat(1000, -1000, 8388607, "R1 unity after reset");

    // R2 hold when idle
    @(negedge aud_clk);
    check("R2 out_valid idle", out_valid, 0);
    check("R2 out_data hold", $signed(out_data[DW-1:0]), 1000);

    // R5/R6: pending held with same sign, committed at sign change
    beat(500, 500, 500, "R5 prime");
    write(0, 243, 1);
    for (int i = 0; i < 5; i++) beat(4000 + i, 7, 7, "R5 held pending");
    beat(-4000, 7, 7, "R6 crossing sample uses old gain");
    beat(-4000, 7, 7, "R6 next sample uses new gain");
    // zero sample commits
    write(1, 200, 1);
    beat(100, 0, 5, "R6 zero sample commit");
    beat(100, 60000, 5, "R6 after zero commit");

    // R8 independence and out-of-range channel
    write(3, 0, 0);
    beat(0, 0, 0, "R8 ignored channel");
    beat(1234567, -1234567, 7654321, "R8 ignored channel gains");
    write(2, 1, 1);
    beat(-5, -5, -5, "R8 only channel 2 moves");
    beat(300000, 300000, 300000, "R8 others unchanged");

    // R9 overwrite before commit
    write(1, 10, 1);
    write(1, 230, 1);
    beat(9, -9, 9, "R9 crossing commits latest");
    beat(9, -99999, 9, "R9 latest code applied");

    // R7 timeout: same-sign samples only
    beat(50, 50, 50, "R7 prime");
    write(0, 100, 1);
    for (int i = 0; i < TO - 1; i++) beat(3000000, 20, 20, "R7 waiting");
    beat(3000000, 20, 20, "R7 timeout sample uses old gain");
    beat(3000000, 20, 20, "R7 after timeout new gain");

    // R3/R4 sweep of every code on channel 2 (code 0 = mute)
    for (int code = 0; code < 256; code++) begin
      write(2, code, 1);
      beat(11, 11, 0, "R3 sweep commit");
      beat(8388607, 1, 8388607, "R3 sweep max");
      beat(-8388608, 1, -8388608, "R4 sweep min");
      beat(-3, 1, -3, "R4 sweep rounding");
      beat(65537, 1, 65537, "R4 sweep mid");
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule